// File: doc/BRIEF.md
# Float to integer and fixed-point converter

This unit turns an IEEE-754 single-precision operand into a 32-bit result in one of four target formats: a signed integer, an unsigned integer, a signed fraction covering [-1, 1), or an unsigned fraction covering [0, 1). An 11-bit function code picks the target format and says whether to truncate or to round by the rounding mode on `rmode_i`. The result comes back together with an invalid flag and an inexact flag.

The datapath is combinational and the three outputs are registered. Inputs sampled at one rising clock edge show up on the outputs right after that edge. For fraction targets, the operand's exponent is raised by 31 (signed) or 32 (unsigned), and the operand then goes through the same rounded integer conversion as the integer targets. Values outside the target range saturate, and NaNs convert to zero.

Top module: `fcvt_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs after that edge are `res_o` = 0, `invalid_o` = 0 and `inexact_o` = 0.
- R2: The conversion of the inputs sampled at a rising edge appears on the outputs right after that edge, so the latency is one clock.
- R3: The legal function codes are 0x2d4 (unsigned integer, by mode), 0x2d5 (signed integer, by mode), 0x2d8 (unsigned integer, truncating), 0x2da (signed integer, truncating), 0x2d6 (unsigned fraction) and 0x2d7 (signed fraction). An integer code is signed when its low two bits are nonzero. A fraction code is signed when bit 0 is set. The operand's sign never selects signedness.
- R4: Codes 0x2d8 and 0x2da always round toward zero, whatever the value of `rmode_i`.
- R5: Codes with bit 2 set (0x2d4 to 0x2d7) round by `rmode_i`: 0 is nearest with ties to even, 1 is toward zero, 2 is toward +infinity, 3 is toward -infinity.
- R6: A NaN operand of either sign gives `res_o` = 0 with `invalid_o` = 1 and `inexact_o` = 0.
- R7: For a signed target, a rounded value above 2^31-1 gives 0x7FFFFFFF and a rounded value below -2^31 gives 0x80000000. Both cases set `invalid_o` and clear `inexact_o`.
- R8: For an unsigned target, a rounded value above 2^32-1 gives 0xFFFFFFFF with `invalid_o` set. A negative operand whose rounded magnitude is nonzero gives 0 with `invalid_o` set. A negative operand whose magnitude rounds to 0 gives 0 without `invalid_o`.
- R9: A fraction code returns the operand scaled by 2^31 (signed) or 2^32 (unsigned), rounded by `rmode_i`. Subnormal operands are rounded the same way and are not forced to 0.
- R10: An infinite operand saturates the way an out-of-range finite value of the same sign does, and sets `invalid_o`.
- R11: `inexact_o` is set exactly when nonzero bits were discarded and the result did not saturate. `invalid_o` and `inexact_o` are never both set.
- R12: Any other function code gives `res_o` = 0 with both flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 32 | Single-precision operand |
| func_i | input | 11 | Function code selecting target format and rounding |
| rmode_i | input | 2 | Rounding mode used by the by-mode codes |
| res_o | output | 32 | Converted result |
| invalid_o | output | 1 | NaN, infinity or saturated result |
| inexact_o | output | 1 | Bits discarded without saturation |

## Verification
Halfway values such as 2.5, 3.5 and -2.5 are driven under every rounding mode, which separates ties-to-even from the directed modes and shows which way a negative value moves. Operands at the exact range edges (2^31, -2^31, 2^32 and their float neighbours) separate saturation from exact conversion. Small negative values sent to unsigned targets separate rounding to zero from saturation to zero. Subnormals and values near 0.5 and 1.0 on the fraction codes show the exponent bias and mode rounding at work. Several thousand random operands spread around the integer range check the remaining combinations against a reference model built on real arithmetic.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;

  localparam int FUNC_W = 11;

  localparam logic [FUNC_W-1:0] FN_UINT_RM = 11'h2d4;
  localparam logic [FUNC_W-1:0] FN_SINT_RM = 11'h2d5;
  localparam logic [FUNC_W-1:0] FN_UFRAC   = 11'h2d6;
  localparam logic [FUNC_W-1:0] FN_SFRAC   = 11'h2d7;
  localparam logic [FUNC_W-1:0] FN_UINT_TZ = 11'h2d8;
  localparam logic [FUNC_W-1:0] FN_SINT_TZ = 11'h2da;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_ZERO    = 2'd1,
    RM_UP      = 2'd2,
    RM_DOWN    = 2'd3
  } rmode_e;

  typedef enum logic [1:0] {
    CL_ZERO   = 2'd0,
    CL_FINITE = 2'd1,
    CL_INF    = 2'd2,
    CL_NAN    = 2'd3
  } fclass_e;

  typedef struct packed {
    logic legal;
    logic signed_tgt;
    logic fraction;
    logic by_mode;
  } op_ctl_t;

endpackage

// File: rtl/fcvt_decode.sv
module fcvt_decode
  import fcvt_pkg::*;
(
  input  logic [FUNC_W-1:0] func_i,
  output op_ctl_t           ctl_o
);

  logic legal;
  logic frac;

  always_comb begin
    legal = 1'b0;
    case (func_i)
      FN_UINT_RM, FN_SINT_RM, FN_UFRAC,
      FN_SFRAC, FN_UINT_TZ, FN_SINT_TZ: legal = 1'b1;
      default:                          legal = 1'b0;
    endcase
    frac = (func_i == FN_UFRAC) || (func_i == FN_SFRAC);
  end

  // Integer codes: signed when either low bit is set; fraction codes: bit 0.
  always_comb begin
    ctl_o.legal      = legal;
    ctl_o.fraction   = legal & frac;
    ctl_o.by_mode    = legal & func_i[2];
    ctl_o.signed_tgt = legal & (frac ? func_i[0] : (|func_i[1:0]));
  end

endmodule

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
  import fcvt_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int OP_W  = 1 + EXP_W + MAN_W,
  localparam int SIG_W = MAN_W + 1,
  localparam int XW    = EXP_W + 2
) (
  input  logic [OP_W-1:0]         op_i,
  output logic                    sign_o,
  output fclass_e                 cls_o,
  output logic [SIG_W-1:0]        sig_o,
  output logic signed [XW-1:0]    lsb_exp_o
);

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic [EXP_W-1:0] efield;
  logic [MAN_W-1:0] mfield;
  logic [EXP_W-1:0] eadj;

  assign efield = op_i[MAN_W +: EXP_W];
  assign mfield = op_i[MAN_W-1:0];
  assign sign_o = op_i[OP_W-1];

  always_comb begin
    if (&efield)
      cls_o = (|mfield) ? CL_NAN : CL_INF;
    else if ((efield == '0) && (mfield == '0))
      cls_o = CL_ZERO;
    else
      cls_o = CL_FINITE;
  end

  // Subnormals share the exponent of the smallest normal, hidden bit clear.
  assign eadj      = (efield == '0) ? EXP_W'(1) : efield;
  assign sig_o     = {(efield != '0), mfield};
  assign lsb_exp_o = $signed({2'b00, eadj}) - XW'(BIAS + MAN_W);

endmodule

// File: rtl/fcvt_round.sv
module fcvt_round
  import fcvt_pkg::*;
#(
  parameter int SIG_W = 24,
  parameter int RES_W = 32,
  parameter int XW    = 10,
  localparam int MAG_W = SIG_W + RES_W + 1
) (
  input  logic [SIG_W-1:0]     sig_i,
  input  logic signed [XW-1:0] scale_i,
  input  logic                 sign_i,
  input  rmode_e               rmode_i,
  output logic [MAG_W-1:0]     mag_o,
  output logic                 big_o,
  output logic                 lost_o
);

  localparam int RCAP  = SIG_W + 2;
  localparam int EXT_W = SIG_W + RCAP;

  logic [MAG_W-1:0] mag_pre;
  logic [EXT_W-1:0] ext;
  logic [XW-1:0]    rsh;
  logic             guard;
  logic             sticky;
  logic             inc;

  always_comb begin
    mag_pre = '0;
    ext     = '0;
    rsh     = '0;
    guard   = 1'b0;
    sticky  = 1'b0;
    big_o   = 1'b0;
    if (!scale_i[XW-1]) begin
      // Left shift: exact integer, or certainly out of range.
      if (scale_i > XW'(RES_W))
        big_o = |sig_i;
      else
        mag_pre = MAG_W'(sig_i) << scale_i;
    end else begin
      rsh = -scale_i;
      if (rsh > XW'(RCAP))
        rsh = XW'(RCAP);
      ext     = {sig_i, {RCAP{1'b0}}} >> rsh;
      mag_pre = MAG_W'(ext[EXT_W-1 -: SIG_W]);
      guard   = ext[RCAP-1];
      sticky  = |ext[RCAP-2:0];
    end
  end

  always_comb begin
    case (rmode_i)
      RM_NEAREST: inc = guard & (sticky | mag_pre[0]);
      RM_UP:      inc = (guard | sticky) & ~sign_i;
      RM_DOWN:    inc = (guard | sticky) & sign_i;
      default:    inc = 1'b0;
    endcase
  end

  assign mag_o  = mag_pre + MAG_W'(inc);
  assign lost_o = guard | sticky;

endmodule

// File: rtl/fcvt_sat.sv
module fcvt_sat
  import fcvt_pkg::*;
#(
  parameter int RES_W = 32,
  parameter int MAG_W = 57
) (
  input  logic             legal_i,
  input  logic             signed_i,
  input  fclass_e          cls_i,
  input  logic             sign_i,
  input  logic [MAG_W-1:0] mag_i,
  input  logic             big_i,
  input  logic             lost_i,
  output logic [RES_W-1:0] res_o,
  output logic             invalid_o,
  output logic             inexact_o
);

  localparam int HI_W = MAG_W - RES_W;

  localparam logic [MAG_W-1:0] LIM_SPOS = {{(HI_W + 1){1'b0}}, {(RES_W - 1){1'b1}}};
  localparam logic [MAG_W-1:0] LIM_SNEG = {{HI_W{1'b0}}, 1'b1, {(RES_W - 1){1'b0}}};
  localparam logic [MAG_W-1:0] LIM_U    = {{HI_W{1'b0}}, {RES_W{1'b1}}};

  localparam logic [RES_W-1:0] SAT_SPOS = {1'b0, {(RES_W - 1){1'b1}}};
  localparam logic [RES_W-1:0] SAT_SNEG = {1'b1, {(RES_W - 1){1'b0}}};
  localparam logic [RES_W-1:0] SAT_U    = {RES_W{1'b1}};

  logic             ovr;
  logic [RES_W-1:0] low;

  assign ovr = (cls_i == CL_INF) | big_i;
  assign low = mag_i[RES_W-1:0];

  always_comb begin
    res_o     = '0;
    invalid_o = 1'b0;
    inexact_o = 1'b0;
    if (!legal_i) begin
      res_o = '0;
    end else if (cls_i == CL_NAN) begin
      invalid_o = 1'b1;
    end else if (signed_i) begin
      if (!sign_i && (ovr || (mag_i > LIM_SPOS))) begin
        res_o     = SAT_SPOS;
        invalid_o = 1'b1;
      end else if (sign_i && (ovr || (mag_i > LIM_SNEG))) begin
        res_o     = SAT_SNEG;
        invalid_o = 1'b1;
      end else begin
        res_o     = sign_i ? (~low + 1'b1) : low;
        inexact_o = lost_i;
      end
    end else begin
      if (sign_i) begin
        if (ovr || (mag_i != '0))
          invalid_o = 1'b1;
        else
          inexact_o = lost_i;
      end else if (ovr || (mag_i > LIM_U)) begin
        res_o     = SAT_U;
        invalid_o = 1'b1;
      end else begin
        res_o     = low;
        inexact_o = lost_i;
      end
    end
  end

endmodule

// File: rtl/fcvt_unit.sv
module fcvt_unit
  import fcvt_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int RES_W = 32,
  localparam int OP_W  = 1 + EXP_W + MAN_W,
  localparam int SIG_W = MAN_W + 1,
  localparam int XW    = EXP_W + 2,
  localparam int MAG_W = SIG_W + RES_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   op_i,
  input  logic [FUNC_W-1:0] func_i,
  input  logic [1:0]        rmode_i,
  output logic [RES_W-1:0]  res_o,
  output logic              invalid_o,
  output logic              inexact_o
);

  op_ctl_t              ctl;
  logic                 sign;
  fclass_e              cls;
  logic [SIG_W-1:0]     sig;
  logic signed [XW-1:0] lsb_exp;
  logic signed [XW-1:0] frac_add;
  logic signed [XW-1:0] scale;
  rmode_e               rm_eff;
  logic [MAG_W-1:0]     mag;
  logic                 big;
  logic                 lost;
  logic [RES_W-1:0]     res_d;
  logic                 inv_d;
  logic                 inx_d;

  fcvt_decode u_dec (
    .func_i (func_i),
    .ctl_o  (ctl)
  );

  fcvt_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unp (
    .op_i      (op_i),
    .sign_o    (sign),
    .cls_o     (cls),
    .sig_o     (sig),
    .lsb_exp_o (lsb_exp)
  );

  // Fraction targets: raise the exponent, then round like an integer.
  assign frac_add = ctl.fraction ? (ctl.signed_tgt ? XW'(RES_W - 1) : XW'(RES_W)) : '0;
  assign scale    = lsb_exp + frac_add;
  assign rm_eff   = ctl.by_mode ? rmode_e'(rmode_i) : RM_ZERO;

  fcvt_round #(.SIG_W(SIG_W), .RES_W(RES_W), .XW(XW)) u_rnd (
    .sig_i   (sig),
    .scale_i (scale),
    .sign_i  (sign),
    .rmode_i (rm_eff),
    .mag_o   (mag),
    .big_o   (big),
    .lost_o  (lost)
  );

  fcvt_sat #(.RES_W(RES_W), .MAG_W(MAG_W)) u_sat (
    .legal_i   (ctl.legal),
    .signed_i  (ctl.signed_tgt),
    .cls_i     (cls),
    .sign_i    (sign),
    .mag_i     (mag),
    .big_i     (big),
    .lost_i    (lost),
    .res_o     (res_d),
    .invalid_o (inv_d),
    .inexact_o (inx_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o     <= '0;
      invalid_o <= 1'b0;
      inexact_o <= 1'b0;
    end else begin
      res_o     <= res_d;
      invalid_o <= inv_d;
      inexact_o <= inx_d;
    end
  end

endmodule

// File: rtl/fcvt_chk.sv
module fcvt_chk
  import fcvt_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int RES_W = 32,
  localparam int OP_W = 1 + EXP_W + MAN_W
) (
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   op_i,
  input logic [FUNC_W-1:0] func_i,
  input logic [RES_W-1:0]  res_o,
  input logic              invalid_o,
  input logic              inexact_o
);

  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic code_ok, code_uns, code_tz, in_nan, in_inf, in_neg, in_small;

  assign code_ok  = (func_i == FN_UINT_RM) || (func_i == FN_SINT_RM) ||
                    (func_i == FN_UFRAC)   || (func_i == FN_SFRAC)   ||
                    (func_i == FN_UINT_TZ) || (func_i == FN_SINT_TZ);
  assign code_uns = (func_i == FN_UINT_RM) || (func_i == FN_UFRAC) || (func_i == FN_UINT_TZ);
  assign code_tz  = (func_i == FN_UINT_TZ) || (func_i == FN_SINT_TZ);
  assign in_nan   = (&op_i[MAN_W +: EXP_W]) && (|op_i[MAN_W-1:0]);
  assign in_inf   = (&op_i[MAN_W +: EXP_W]) && !(|op_i[MAN_W-1:0]);
  assign in_neg   = op_i[OP_W-1];
  assign in_small = op_i[MAN_W +: EXP_W] < EXP_W'(BIAS);

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (res_o == '0) && !invalid_o && !inexact_o);

  // R6
  a_r6_nan_zero: assert property (@(posedge clk) disable iff (rst)
    (code_ok && in_nan) |=> (res_o == '0) && invalid_o && !inexact_o);

  // R12
  a_r12_bad_code: assert property (@(posedge clk) disable iff (rst)
    !code_ok |=> (res_o == '0) && !invalid_o && !inexact_o);

  // R8
  a_r8_neg_unsigned: assert property (@(posedge clk) disable iff (rst)
    (code_uns && in_neg && !in_nan) |=> (res_o == '0));

  // R10
  a_r10_inf_invalid: assert property (@(posedge clk) disable iff (rst)
    (code_ok && in_inf) |=> invalid_o && !inexact_o);

  // R4
  a_r4_trunc_fraction: assert property (@(posedge clk) disable iff (rst)
    (code_tz && in_small) |=> (res_o == '0) && !invalid_o);

  // R11
  a_r11_flags_apart: assert property (@(posedge clk) disable iff (rst)
    !(invalid_o && inexact_o));

endmodule

bind fcvt_unit fcvt_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .RES_W(RES_W)) u_chk (.*);

// File: tb/sim_fcvt_unit.sv
module sim_fcvt_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] op  = 32'h4040_0000;
  logic [10:0] fn  = 11'h2d5;
  logic [1:0]  rm  = 2'd0;
  logic [31:0] res;
  logic        inv;
  logic        inx;

  fcvt_unit u0 (
    .clk       (clk),
    .rst       (rst),
    .op_i      (op),
    .func_i    (fn),
    .rmode_i   (rm),
    .res_o     (res),
    .invalid_o (inv),
    .inexact_o (inx)
  );

  always #10 clk = ~clk;

  int          checks = 0;
  int          errors = 0;
  bit          done   = 0;
  bit          pend   = 0;
  logic [33:0] pexp;
  string       ptag;

  // Reference: real arithmetic on the requirements, result {value, invalid, inexact}.
  function automatic logic [33:0] model(input logic [31:0] o, input logic [10:0] f,
                                        input logic [1:0] r);
    bit legal, frac, sgn_t, neg, is_inf, up, lost;
    int ef, mf;
    logic [1:0] m;
    logic [31:0] v;
    real a, t, rem;
    legal = (f == 11'h2d4) || (f == 11'h2d5) || (f == 11'h2d6) ||
            (f == 11'h2d7) || (f == 11'h2d8) || (f == 11'h2da);
    if (!legal) return 34'd0;
    ef  = int'(o[30:23]);
    mf  = int'(o[22:0]);
    neg = o[31];
    if (ef == 255 && mf != 0) return {32'd0, 2'b10};
    frac   = (f == 11'h2d6) || (f == 11'h2d7);
    sgn_t  = frac ? f[0] : (f[1:0] != 2'b00);
    m      = f[2] ? r : 2'd1;
    is_inf = (ef == 255);
    if (ef == 0) a = real'(mf) * (2.0 ** (-149.0));
    else         a = real'(mf + 8388608) * (2.0 ** real'(ef - 150));
    if (frac) a = a * (sgn_t ? 2147483648.0 : 4294967296.0);
    t    = $floor(a);
    rem  = a - t;
    lost = rem > 0.0;
    up   = 0;
    case (m)
      2'd0: up = (rem > 0.5) || ((rem == 0.5) && ($floor(t / 2.0) * 2.0 != t));
      2'd2: up = lost && !neg;
      2'd3: up = lost && neg;
      default: up = 0;
    endcase
    if (up) t = t + 1.0;
    if (sgn_t) begin
      if (!neg && (is_inf || t > 2147483647.0)) return {32'h7fff_ffff, 2'b10};
      if (neg && (is_inf || t > 2147483648.0))  return {32'h8000_0000, 2'b10};
      v = 32'(longint'(t));
      if (neg) v = -v;
      return {v, 1'b0, lost};
    end
    if (neg) begin
      if (is_inf || t > 0.0) return {32'd0, 2'b10};
      return {32'd0, 1'b0, lost};
    end
    if (is_inf || t > 4294967295.0) return {32'hffff_ffff, 2'b10};
    v = 32'(longint'(t));
    return {v, 1'b0, lost};
  endfunction

  task automatic check_now();
    if (pend) begin
      checks++;
      if ({res, inv, inx} !== pexp) begin
        errors++;
        $display("FAIL %s: op=%h fn=%h rm=%0d got res=%h inv=%b inx=%b expected res=%h inv=%b inx=%b",
                 ptag, op, fn, rm, res, inv, inx, pexp[33:2], pexp[1], pexp[0]);
      end
    end
  endtask

  task automatic drive(input logic [31:0] o, input logic [10:0] f, input logic [1:0] r,
                       input string tag);
    @(negedge clk);
    check_now();
    rst  = 1'b0;
    op   = o;
    fn   = f;
    rm   = r;
    pexp = model(o, f, r);
    ptag = tag;
    pend = 1;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    // R1: reset holds outputs at zero even with a live operand.
    @(negedge clk);
    op = 32'h7f80_0000; fn = 11'h2d5; rm = 2'd2;
    pexp = 34'd0; ptag = "R1 reset"; pend = 1;
    @(negedge clk); check_now();
    @(negedge clk); check_now();

    // R2: back-to-back vectors each appear one clock later.
    drive(32'h40a0_0000, 11'h2d5, 2'd0, "R2 latency first");
    drive(32'h40e0_0000, 11'h2d5, 2'd0, "R2 latency second");
    // R3: code decode and signedness.
    drive(32'h4040_0000, 11'h2d5, 2'd0, "R3 signed int");
    drive(32'h4040_0000, 11'h2d4, 2'd0, "R3 unsigned int");
    drive(32'hc040_0000, 11'h2d5, 2'd0, "R3 negative signed");
    drive(32'h4f40_0000, 11'h2d4, 2'd0, "R3 unsigned above 2^31");
    // R4: truncating codes ignore the mode.
    drive(32'h3ff0_0000, 11'h2da, 2'd2, "R4 trunc up-mode");
    drive(32'hbff0_0000, 11'h2da, 2'd3, "R4 trunc down-mode");
    drive(32'h3ff0_0000, 11'h2d8, 2'd0, "R4 trunc unsigned");
    // R5: mode rounding, ties to even.
    drive(32'h4020_0000, 11'h2d5, 2'd0, "R5 2.5 nearest");
    drive(32'h4060_0000, 11'h2d5, 2'd0, "R5 3.5 nearest");
    drive(32'h4020_0000, 11'h2d5, 2'd2, "R5 2.5 up");
    drive(32'hc020_0000, 11'h2d5, 2'd3, "R5 -2.5 down");
    drive(32'hc020_0000, 11'h2d5, 2'd2, "R5 -2.5 up");
    drive(32'h4020_0000, 11'h2d5, 2'd1, "R5 2.5 zero");
    drive(32'hc060_0000, 11'h2d5, 2'd0, "R5 -3.5 nearest");
    // R6: NaNs of both signs.
    drive(32'h7fc0_0000, 11'h2d5, 2'd0, "R6 positive NaN");
    drive(32'hffc0_0001, 11'h2d6, 2'd2, "R6 negative NaN");
    // R7: signed saturation edges.
    drive(32'h4f00_0000, 11'h2d5, 2'd0, "R7 2^31 saturate");
    drive(32'hcf00_0000, 11'h2d5, 2'd0, "R7 -2^31 exact");
    drive(32'hcf00_0001, 11'h2d5, 2'd0, "R7 below -2^31");
    drive(32'h4eff_ffff, 11'h2da, 2'd0, "R7 largest in range");
    // R8: unsigned saturation and negatives.
    drive(32'h4f80_0000, 11'h2d4, 2'd0, "R8 2^32 saturate");
    drive(32'h4f7f_ffff, 11'h2d4, 2'd0, "R8 largest exact");
    drive(32'hbf80_0000, 11'h2d4, 2'd0, "R8 -1 to unsigned");
    drive(32'hbe80_0000, 11'h2d8, 2'd0, "R8 -0.25 truncates");
    drive(32'hbe80_0000, 11'h2d4, 2'd3, "R8 -0.25 rounds away");
    // R9: fraction targets, including subnormals.
    drive(32'h3f00_0000, 11'h2d7, 2'd0, "R9 0.5 signed frac");
    drive(32'h3f00_0000, 11'h2d6, 2'd0, "R9 0.5 unsigned frac");
    drive(32'hbf80_0000, 11'h2d7, 2'd0, "R9 -1 signed frac");
    drive(32'h3f80_0000, 11'h2d7, 2'd0, "R9 1.0 signed frac");
    drive(32'h0000_0001, 11'h2d6, 2'd2, "R9 subnormal up");
    drive(32'h0000_0001, 11'h2d6, 2'd0, "R9 subnormal nearest");
    drive(32'h8000_0001, 11'h2d7, 2'd3, "R9 negative subnormal down");
    // R10: infinities.
    drive(32'h7f80_0000, 11'h2d5, 2'd0, "R10 +inf signed");
    drive(32'hff80_0000, 11'h2d7, 2'd0, "R10 -inf signed frac");
    drive(32'h7f80_0000, 11'h2d4, 2'd0, "R10 +inf unsigned");
    // R11: inexact only on discarded bits.
    drive(32'h3fc0_0000, 11'h2d4, 2'd1, "R11 1.5 inexact");
    drive(32'h4080_0000, 11'h2d4, 2'd1, "R11 4.0 exact");
    // R12: unsupported codes.
    drive(32'h4040_0000, 11'h2d9, 2'd0, "R12 code 2d9");
    drive(32'h7fc0_0000, 11'h2d3, 2'd0, "R12 code 2d3");
    drive(32'h4040_0000, 11'h000, 2'd0, "R12 code 000");

    seed = 32'h1234_5678;
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] o;
      logic [10:0] f;
      logic [7:0]  e;
      int          k;
      string       tag;
      seed = seed * 32'd1664525 + 32'd1013904223;
      o    = seed;
      seed = seed * 32'd1664525 + 32'd1013904223;
      k    = int'(seed[31:28]);
      if (seed[27:26] != 2'b00) begin
        e = 8'(100 + int'(seed[25:20]) % 70);
        o[30:23] = e;
      end
      case (k % 7)
        0: f = 11'h2d4;
        1: f = 11'h2d5;
        2: f = 11'h2d6;
        3: f = 11'h2d7;
        4: f = 11'h2d8;
        5: f = 11'h2da;
        default: f = 11'h2d9;
      endcase
      if (f == 11'h2d6 || f == 11'h2d7) tag = "R9 random";
      else if (f == 11'h2d8 || f == 11'h2da) tag = "R4 random";
      else if (f == 11'h2d9) tag = "R12 random";
      else tag = "R5 random";
      drive(o, f, seed[19:18], tag);
    end

    @(negedge clk);
    check_now();
    pend = 0;
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule